// File: doc/BRIEF.md
# T1 Transmit Channel Formatter

This block sits in the transmit path of a 1.544 Mb/s T1 framer, just ahead of line coding. A timing generator steps it through the frame one bit slot at a time. For each slot it receives the serial data bit, a flag that marks the framing-bit slot, the channel number (0 to 23), the bit position inside the channel word (0 is the first bit sent, the MSB; 7 is the LSB) and the frame number inside the superframe. It also receives the robbed-bit signaling input and a set of static control inputs. It rewrites each 8-bit channel word according to a fixed precedence and returns the formatted serial stream.

The precedence is as follows. Idle code substitution comes first. Robbed-bit signaling is inserted next, and it also applies to idle channels. A zero-suppression stage then forces bit 7 of an all-zero word to one. The 12-frame yellow alarm clears bit 2 of every channel. The blue alarm overrides all of these. Transparent channels skip signaling and zero suppression. The zero test must know the whole word before bit 7 goes out, so the stream passes through an 8-slot delay line. Framing slots travel through the same delay line unchanged, so the output keeps exact frame alignment.

Top module: `tx_chan_formatter`

## Requirements
- R1: Each slot accepted with `slot_en` high appears at `fmt_out` after exactly 8 accepted slots. Framing slots (`f_slot` high) and words that no other rule touches pass through with the input value.
- R2: Channel n takes its idle flag and its transparency flag from bit n mod 8 of the map register n/8. Channels 0-7 use `idle_lo`/`clear_lo`, channels 8-15 use `idle_mid`/`clear_mid`, and channels 16-23 use `idle_hi`/`clear_hi`.
- R3: An idle channel sends 8'h7F in place of its data when `idle_all_ones` is 0, and 8'hFF when it is 1. The code is sent MSB first, at bit position 0.
- R4: When `sig_en` is set, the LSB of every non-transparent channel (idle channels included) is replaced by `sig_in` in signaling frames. With `frame_idx` counted from 0, the signaling frames are 5 and 11 in 12-frame mode (`esf_mode`=0) and 5, 11, 17 and 23 in 24-frame mode.
- R5: A transparent channel receives neither signaling nor zero suppression. Its idle substitution still applies.
- R6: When `stuff_en` is set, a non-transparent word that is all zero after idle and signaling substitution is sent with bit 7 (bit position 6) forced to 1.
- R7: In 12-frame mode with `yel_en` set and `yel_sbit` clear, bit 2 (bit position 1) of every channel is sent as 0. The zero test of R6 ignores this forcing. The forcing does not occur in 24-frame mode or when `yel_sbit` is set.
- R8: While `blue_en` is high, `fmt_out` is 1 in every slot, framing slots included, from the same cycle on.
- R9: Reset clears the delay line, so `fmt_out` is 0 during reset and for the first 8 accepted slots after reset, unless `blue_en` is high.
- R10: A cycle with `slot_en` low advances nothing. `fmt_out` holds its value unless `blue_en` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_en | input | 1 | Accept one bit slot this cycle |
| f_slot | input | 1 | Current slot is the framing bit |
| ser_in | input | 1 | Serial data bit for the slot |
| chan_idx | input | 5 | Channel number 0..23 |
| bit_idx | input | 3 | Bit position in channel word, 0 = MSB |
| frame_idx | input | 5 | Frame number within superframe, from 0 |
| sig_in | input | 1 | Robbed-bit signaling bit |
| esf_mode | input | 1 | 1 = 24-frame superframe, 0 = 12-frame |
| sig_en | input | 1 | Enable robbed-bit signaling |
| idle_all_ones | input | 1 | Idle code select: 0 = 7F, 1 = FF |
| stuff_en | input | 1 | Enable bit-7 zero suppression |
| yel_en | input | 1 | Yellow alarm active |
| yel_sbit | input | 1 | Yellow carried elsewhere (no bit-2 forcing) |
| blue_en | input | 1 | Send unframed all ones |
| idle_lo | input | 8 | Idle flags, channels 0-7 |
| idle_mid | input | 8 | Idle flags, channels 8-15 |
| idle_hi | input | 8 | Idle flags, channels 16-23 |
| clear_lo | input | 8 | Transparency flags, channels 0-7 |
| clear_mid | input | 8 | Transparency flags, channels 8-15 |
| clear_hi | input | 8 | Transparency flags, channels 16-23 |
| fmt_out | output | 1 | Formatted serial output |

## Verification
Some rules are local in time and are checked on every cycle. These are the blue override, the hold when no slot is accepted, and the bit that enters the delay line for idle bit 1, for signaling slots, for transparent LSBs and for forced yellow bits. A stuffing decision must also reach the bit-7 position one cycle later. Other behaviour depends on whole words and whole superframes, and only the bench scenarios show it. This covers the 8-slot latency, the channel-to-register mapping, the choice of signaling frames in each superframe mode, and the interplay of idle, transparency, zero suppression and yellow. The bench compares every output slot against a word-level model over full superframes.

// File: rtl/tfmt_pkg.sv
`timescale 1ns/1ps
package tfmt_pkg;

  localparam int FRAME_SF  = 12;
  localparam int FRAME_ESF = 24;
  localparam int SIG_STEP  = 6;

  // Robbed-bit signaling frames: every sixth frame of the superframe.
  function automatic logic is_sig_frame(input logic [4:0] frame, input logic esf);
    int n;
    n = int'(frame) + 1;
    return ((n % SIG_STEP) == 0) && (n <= (esf ? FRAME_ESF : FRAME_SF));
  endfunction

  // Idle code bit: the first (MSB) bit selects 7F versus FF, the rest are ones.
  function automatic logic idle_code_bit(input logic [2:0] pos, input logic all_ones);
    return (pos == 3'd0) ? all_ones : 1'b1;
  endfunction

endpackage

// File: rtl/tfmt_chan_sel.sv
`timescale 1ns/1ps
module tfmt_chan_sel #(
  parameter int NUM_CH = 24,
  parameter int IDX_W  = 5
) (
  input  logic [NUM_CH-1:0] idle_vec,
  input  logic [NUM_CH-1:0] clear_vec,
  input  logic [IDX_W-1:0]  chan_idx,
  output logic              idle_cur,
  output logic              clear_cur
);
  logic in_range;

  always_comb begin
    in_range  = (int'(chan_idx) < NUM_CH);
    idle_cur  = 1'b0;
    clear_cur = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (in_range && (int'(chan_idx) == i)) begin
        idle_cur  = idle_vec[i];
        clear_cur = clear_vec[i];
      end
    end
  end
endmodule

// File: rtl/tfmt_bit_mux.sv
`timescale 1ns/1ps
module tfmt_bit_mux
  import tfmt_pkg::*;
#(
  parameter int CH_W  = 8,
  parameter int BIT_W = 3
) (
  input  logic             f_slot,
  input  logic             ser_in,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic [4:0]       frame_idx,
  input  logic             sig_in,
  input  logic             esf_mode,
  input  logic             sig_en,
  input  logic             idle_all_ones,
  input  logic             yel_en,
  input  logic             yel_sbit,
  input  logic             idle_cur,
  input  logic             clear_cur,
  output logic             word_bit,
  output logic             line_bit,
  output logic             sig_sel,
  output logic             yel_force
);
  localparam logic [BIT_W-1:0] LSB_POS  = BIT_W'(CH_W - 1);
  localparam logic [BIT_W-1:0] BIT2_POS = BIT_W'(1);

  logic base_bit;

  always_comb begin
    base_bit  = idle_cur ? idle_code_bit(3'(bit_idx), idle_all_ones) : ser_in;
    sig_sel   = !f_slot && sig_en && !clear_cur && (bit_idx == LSB_POS)
                && is_sig_frame(frame_idx, esf_mode);
    word_bit  = f_slot ? ser_in : (sig_sel ? sig_in : base_bit);
    yel_force = !f_slot && yel_en && !esf_mode && !yel_sbit && (bit_idx == BIT2_POS);
    line_bit  = word_bit && !yel_force;
  end
endmodule

// File: rtl/tfmt_delay.sv
`timescale 1ns/1ps
module tfmt_delay #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_en,
  input  logic f_slot,
  input  logic first_bit,
  input  logic last_bit,
  input  logic word_bit,
  input  logic line_bit,
  input  logic stuff_ok,
  output logic tail,
  output logic head,
  output logic b7_tap,
  output logic stuff_pulse
);
  logic [DEPTH-1:0] line_q, line_d;
  logic             any_q, any_d, word_zero;

  always_comb begin
    any_d       = (any_q && !first_bit) || word_bit;
    word_zero   = !any_d;
    stuff_pulse = slot_en && !f_slot && last_bit && stuff_ok && word_zero;
    line_d      = {line_q[DEPTH-2:0], line_bit};
    // Bit 7 entered one slot before the LSB, so it now sits one step in.
    if (stuff_pulse) line_d[1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      any_q  <= 1'b0;
    end else if (slot_en) begin
      line_q <= line_d;
      if (!f_slot) any_q <= any_d;
    end
  end

  assign tail   = line_q[DEPTH-1];
  assign head   = line_q[0];
  assign b7_tap = line_q[1];
endmodule

// File: rtl/tx_chan_formatter.sv
`timescale 1ns/1ps
module tx_chan_formatter #(
  parameter int MAP_W = 8,
  parameter int CH_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     slot_en,
  input  logic                     f_slot,
  input  logic                     ser_in,
  input  logic [4:0]               chan_idx,
  input  logic [$clog2(CH_W)-1:0]  bit_idx,
  input  logic [4:0]               frame_idx,
  input  logic                     sig_in,
  input  logic                     esf_mode,
  input  logic                     sig_en,
  input  logic                     idle_all_ones,
  input  logic                     stuff_en,
  input  logic                     yel_en,
  input  logic                     yel_sbit,
  input  logic                     blue_en,
  input  logic [MAP_W-1:0]         idle_lo,
  input  logic [MAP_W-1:0]         idle_mid,
  input  logic [MAP_W-1:0]         idle_hi,
  input  logic [MAP_W-1:0]         clear_lo,
  input  logic [MAP_W-1:0]         clear_mid,
  input  logic [MAP_W-1:0]         clear_hi,
  output logic                     fmt_out
);
  localparam int NUM_CH = 3 * MAP_W;
  localparam int BIT_W  = $clog2(CH_W);

  logic [NUM_CH-1:0] idle_vec, clear_vec;
  logic idle_cur, clear_cur;
  logic word_bit, line_bit, sig_sel, yel_force;
  logic first_bit, last_bit, stuff_ok;
  logic tail, line_head, line_b7, stuff_pulse;

  assign idle_vec  = {idle_hi, idle_mid, idle_lo};
  assign clear_vec = {clear_hi, clear_mid, clear_lo};

  tfmt_chan_sel #(.NUM_CH(NUM_CH), .IDX_W(5)) u_sel (
    .idle_vec(idle_vec), .clear_vec(clear_vec), .chan_idx(chan_idx),
    .idle_cur(idle_cur), .clear_cur(clear_cur)
  );

  tfmt_bit_mux #(.CH_W(CH_W), .BIT_W(BIT_W)) u_mux (
    .f_slot(f_slot), .ser_in(ser_in), .bit_idx(bit_idx), .frame_idx(frame_idx),
    .sig_in(sig_in), .esf_mode(esf_mode), .sig_en(sig_en),
    .idle_all_ones(idle_all_ones), .yel_en(yel_en), .yel_sbit(yel_sbit),
    .idle_cur(idle_cur), .clear_cur(clear_cur),
    .word_bit(word_bit), .line_bit(line_bit), .sig_sel(sig_sel), .yel_force(yel_force)
  );

  assign first_bit = (bit_idx == '0);
  assign last_bit  = (bit_idx == BIT_W'(CH_W - 1));
  assign stuff_ok  = stuff_en && !clear_cur;

  tfmt_delay #(.DEPTH(CH_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .f_slot(f_slot),
    .first_bit(first_bit), .last_bit(last_bit), .word_bit(word_bit),
    .line_bit(line_bit), .stuff_ok(stuff_ok),
    .tail(tail), .head(line_head), .b7_tap(line_b7), .stuff_pulse(stuff_pulse)
  );

  assign fmt_out = blue_en || tail;
endmodule

// File: rtl/tx_chan_formatter_chk.sv
`timescale 1ns/1ps
module tx_chan_formatter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       slot_en,
  input logic       f_slot,
  input logic       ser_in,
  input logic [2:0] bit_idx,
  input logic       sig_in,
  input logic       esf_mode,
  input logic       idle_all_ones,
  input logic       yel_en,
  input logic       yel_sbit,
  input logic       blue_en,
  input logic       idle_cur,
  input logic       clear_cur,
  input logic       sig_sel,
  input logic       stuff_pulse,
  input logic       line_head,
  input logic       line_b7,
  input logic       fmt_out
);
  // R8: blue forces ones in the same cycle
  a_r8_blue_ones: assert property (@(posedge clk) disable iff (!rst_n)
    blue_en |-> fmt_out);

  // R10: nothing moves without an accepted slot
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_en && !blue_en) |=> (blue_en || fmt_out == $past(fmt_out)));

  // R3: idle code leading bit follows the code select
  a_r3_idle_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && idle_cur && !f_slot && bit_idx == 3'd0) |=> (line_head == $past(idle_all_ones)));

  // R4: signaling slot carries the signaling input
  a_r4_sig_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && sig_sel) |=> (line_head == $past(sig_in)));

  // R5: transparent non-idle LSB carries serial data
  a_r5_clear_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && clear_cur && !idle_cur && !f_slot && bit_idx == 3'd7) |=> (line_head == $past(ser_in)));

  // R6: a stuffing decision lands on bit 7
  a_r6_stuff_b7: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_pulse |=> line_b7);

  // R7: yellow clears bit 2 in 12-frame mode
  a_r7_yellow_b2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_en && !f_slot && bit_idx == 3'd1 && !esf_mode && yel_en && !yel_sbit) |=> !line_head);
endmodule

bind tx_chan_formatter tx_chan_formatter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .f_slot(f_slot), .ser_in(ser_in),
  .bit_idx(bit_idx), .sig_in(sig_in), .esf_mode(esf_mode),
  .idle_all_ones(idle_all_ones), .yel_en(yel_en), .yel_sbit(yel_sbit),
  .blue_en(blue_en), .idle_cur(idle_cur), .clear_cur(clear_cur),
  .sig_sel(sig_sel), .stuff_pulse(stuff_pulse), .line_head(line_head),
  .line_b7(line_b7), .fmt_out(fmt_out)
);

// File: tb/sim_tx_chan_formatter.sv
`timescale 1ns/1ps
module sim_tx_chan_formatter;
  localparam int SLOTS_F = 193;
  localparam int NFRM    = 24;
  localparam int NSLOT   = SLOTS_F * NFRM;
  localparam int LAT     = 8;
  localparam int NSC     = 8;

  // Flags {esf, sig, idle1s, stuff, yel, ysbit, blue}, idle map, clear map, seed
  localparam logic [62:0] TBL [0:NSC-1] = '{
    {7'b0000000, 24'h000000, 24'h000000, 8'd1},   // R1 plain pass-through
    {7'b0001000, 24'h00F00F, 24'h000000, 8'd2},   // R3 7F idle, R6 stuffing
    {7'b0111000, 24'h0000FF, 24'h00FF0F, 8'd3},   // R4 R5 R2 12-frame signaling
    {7'b1101000, 24'h3C0000, 24'hA5A5A5, 8'd4},   // R4 24-frame signaling
    {7'b0101100, 24'h000F00, 24'h000000, 8'd5},   // R7 yellow bit 2
    {7'b0101110, 24'h000000, 24'h000000, 8'd6},   // R7 yellow via other path
    {7'b1101100, 24'h000000, 24'h000000, 8'd7},   // R7 no forcing in 24-frame
    {7'b0111001, 24'hFFFFFF, 24'h000000, 8'd8}    // R8 blue override
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_en = 1'b0, f_slot = 1'b0, ser_in = 1'b0, sig_in = 1'b0;
  logic [4:0] chan_idx = '0, frame_idx = '0;
  logic [2:0] bit_idx = '0;
  logic esf_mode = 0, sig_en = 0, idle_all_ones = 0, stuff_en = 0;
  logic yel_en = 0, yel_sbit = 0, blue_en = 0;
  logic [7:0] idle_lo = 0, idle_mid = 0, idle_hi = 0;
  logic [7:0] clear_lo = 0, clear_mid = 0, clear_hi = 0;
  logic fmt_out;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  tx_chan_formatter u0 (
    .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .f_slot(f_slot), .ser_in(ser_in),
    .chan_idx(chan_idx), .bit_idx(bit_idx), .frame_idx(frame_idx), .sig_in(sig_in),
    .esf_mode(esf_mode), .sig_en(sig_en), .idle_all_ones(idle_all_ones),
    .stuff_en(stuff_en), .yel_en(yel_en), .yel_sbit(yel_sbit), .blue_en(blue_en),
    .idle_lo(idle_lo), .idle_mid(idle_mid), .idle_hi(idle_hi),
    .clear_lo(clear_lo), .clear_mid(clear_mid), .clear_hi(clear_hi),
    .fmt_out(fmt_out)
  );

  function automatic logic [7:0] data_byte(input int f, input int c, input int seed);
    if (((c + f + seed) % 4) == 0) return 8'h00;
    return 8'((c * 53 + f * 29 + seed * 17) % 256);
  endfunction

  function automatic logic sig_bit(input int f, input int c, input int seed);
    return logic'((c * 3 + f + seed) % 2);
  endfunction

  task automatic check(input string rq, input int sc, input int s, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s scen=%0d slot=%0d actual=%0b expected=%0b", rq, sc, s, act, exp);
    end
  endtask

  // Word-level model of the formatting rules
  task automatic model(input logic [62:0] sc, input int s, output logic b, output string rq);
    int f, pos, c, k, fi, seed;
    logic [7:0] w;
    logic idl, clr, sigd, stf, yel;
    seed = int'(sc[7:0]);
    f = s / SLOTS_F; pos = s % SLOTS_F;
    fi = sc[62] ? f % 24 : f % 12;
    if (sc[56]) begin b = 1'b1; rq = "R8"; return; end
    if (pos == 0) begin b = logic'((f + seed) % 2); rq = "R1"; return; end
    c = (pos - 1) / 8; k = (pos - 1) % 8;
    idl = sc[32 + c]; clr = sc[8 + c];
    w = idl ? (sc[60] ? 8'hFF : 8'h7F) : data_byte(f, c, seed);
    sigd = sc[61] && !clr && (((fi + 1) % 6) == 0);
    if (sigd) w[0] = sig_bit(f, c, seed);
    stf = sc[59] && !clr && (w == 8'h00);
    if (stf) w[1] = 1'b1;
    yel = sc[58] && !sc[62] && !sc[57];
    if (yel) w[6] = 1'b0;
    b = w[7 - k];
    if (k == 1 && yel)            rq = "R7";
    else if (k == 6 && stf)       rq = "R6";
    else if (k == 7 && sigd)      rq = "R4";
    else if (idl && c >= 8)       rq = "R2";
    else if (idl)                 rq = "R3";
    else if (clr)                 rq = "R5";
    else                          rq = "R1";
  endtask

  task automatic drive(input logic [62:0] sc, input int s);
    int f, pos, c, k, seed;
    logic [7:0] d;
    seed = int'(sc[7:0]);
    f = s / SLOTS_F; pos = s % SLOTS_F;
    slot_en = 1'b1;
    frame_idx = 5'(sc[62] ? f % 24 : f % 12);
    if (pos == 0) begin
      f_slot = 1'b1; chan_idx = '0; bit_idx = '0;
      ser_in = logic'((f + seed) % 2); sig_in = 1'b0;
    end else begin
      c = (pos - 1) / 8; k = (pos - 1) % 8;
      d = data_byte(f, c, seed);
      f_slot = 1'b0; chan_idx = 5'(c); bit_idx = 3'(k);
      ser_in = d[7 - k]; sig_in = sig_bit(f, c, seed);
    end
  endtask

  task automatic apply_cfg(input logic [62:0] sc);
    {esf_mode, sig_en, idle_all_ones, stuff_en, yel_en, yel_sbit, blue_en} = sc[62:56];
    {idle_hi, idle_mid, idle_lo}    = sc[55:32];
    {clear_hi, clear_mid, clear_lo} = sc[31:8];
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic held;
    logic eb;
    string rq;
    for (int i = 0; i < NSC; i++) begin
      @(negedge clk);
      rst_n = 1'b0; slot_en = 1'b0;
      apply_cfg(TBL[i]);
      @(posedge clk); @(posedge clk); #1;
      // R9 reset clears the line (R8 when blue)
      check(TBL[i][56] ? "R8" : "R9", i, -1, fmt_out, TBL[i][56]);
      @(negedge clk); rst_n = 1'b1;
      for (int s = 0; s < NSLOT + LAT; s++) begin
        @(negedge clk);
        drive(TBL[i], s);
        @(posedge clk); #1;
        if (s >= LAT - 1) begin
          model(TBL[i], s - (LAT - 1), eb, rq);
          check(rq, i, s - (LAT - 1), fmt_out, eb);
        end else begin
          check(TBL[i][56] ? "R8" : "R9", i, s, fmt_out, TBL[i][56]);
        end
      end
    end

    // R10: stall the slot enable and watch the output hold
    @(negedge clk);
    apply_cfg(TBL[0]);
    drive(TBL[0], 5);
    @(posedge clk); #1;
    held = fmt_out;
    @(negedge clk); slot_en = 1'b0; ser_in = ~ser_in;
    for (int n = 0; n < 5; n++) begin
      @(posedge clk); #1;
      check("R10", 0, n, fmt_out, held);
    end
    // R8: blue takes effect without waiting for a clock edge
    @(negedge clk); blue_en = 1'b1; #1;
    check("R8", 0, -2, fmt_out, 1'b1);
    @(negedge clk); blue_en = 1'b0; #1;
    check("R10", 0, -3, fmt_out, held);
    // R9: a fresh reset clears the line
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    check("R9", 0, -4, fmt_out, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule